// File: doc/BRIEF.md
# Hysteretic Threshold Gate for Dual-Rail Asynchronous Logic

This block models a state-holding threshold gate for four-phase, dual-rail asynchronous logic. It has N one-bit inputs and a single output. The output goes high once at least M of the inputs are high. It goes low again only after every input has dropped. In every other case the output keeps its value. This hysteresis is what lets a wave of data and the following wave of spacers pass cleanly through a pipeline stage.

The state is held in a clocked register so that the gate can be synthesized and tested in an emulation flow. The output therefore follows the inputs one clock later. The parameters select the usual variants: a 2-of-3 gate for adder carry logic, a 3-of-5 gate, and a 2-of-2 gate that behaves as a Muller C-element in completion registers. An illegal pair of M and N stops elaboration.

Top module: `ncl_thr_gate`

## Requirements
- R1: When at least M inputs are high at a rising clock edge, `q` is 1 after that edge.
- R2: When all inputs are low at a rising clock edge, `q` is 0 after that edge.
- R3: When between 1 and M-1 inputs are high at an edge, `q` keeps its previous value after that edge.
- R4: While `rst_n` is low, `q` is 0, and reset acts without waiting for a clock edge.
- R5: A change on `din` does not reach `q` before the next rising clock edge.
- R6: With M=2 and N=3, `q` sets on any two or three high inputs, following R1 to R3.
- R7: With M=3 and N=5, two high inputs do not set `q`, and three high inputs do.
- R8: With M=2 and N=2, the gate acts as a C-element: it sets on 11, clears on 00, and holds on 01 or 10.
- R9: If reset is asserted while the set condition is present, `q` stays 0. After reset is released, the first edge with the set condition still present sets `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulation clock that samples the gate state |
| rst_n | input | 1 | Asynchronous reset, active low; clears the output |
| din | input | N | Threshold inputs, one bit per rail |
| q | output | 1 | Gate output, with hysteresis |

## Verification
Set and clear can never hold at the same time, because M is at least 1. The two functions that can collide in one cycle are therefore reset and the set condition. The bench provokes this by holding two high inputs on the 2-of-3 gate while it pulses reset. It judges the result by two things: `q` must fall at once and stay low for as long as reset is held, and it must rise at the first edge after release. In addition, every vector is sampled just before its edge, which confirms that no input reaches the output early.

// File: rtl/ncl_thr_pkg.sv
package ncl_thr_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_SET   = 2'd1,
      ACT_CLEAR = 2'd2
   } thr_act_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ncl_thr_count.sv
module ncl_thr_count #(
   parameter int unsigned N  = 3,
   parameter int unsigned CW = ncl_thr_pkg::cnt_width(N)
) (
   input  logic [N-1:0]  bits,
   output logic [CW-1:0] ones
);

   logic [CW-1:0] part [N+1];

   assign part[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_acc
      assign part[i+1] = part[i] + CW'(bits[i]);
   end

   assign ones = part[N];

endmodule

// File: rtl/ncl_thr_decide.sv
module ncl_thr_decide
   import ncl_thr_pkg::*;
#(
   parameter int unsigned M  = 2,
   parameter int unsigned N  = 3,
   parameter int unsigned CW = cnt_width(N)
) (
   input  logic [N-1:0]  bits,
   input  logic [CW-1:0] ones,
   output thr_act_e      act
);

   logic set_c;
   logic clr_c;

   if (M == N) begin : g_all
      // C-element style: every input must be high to set
      assign set_c = &bits;
   end else if (M == 1) begin : g_any
      assign set_c = |bits;
   end else begin : g_thr
      assign set_c = (ones >= CW'(M));
   end

   assign clr_c = ~|bits;

   always_comb begin
      if (set_c)      act = ACT_SET;
      else if (clr_c) act = ACT_CLEAR;
      else            act = ACT_HOLD;
   end

endmodule

// File: rtl/ncl_thr_state.sv
module ncl_thr_state
   import ncl_thr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  thr_act_e act,
   output logic     q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else begin
         case (act)
            ACT_SET:   q <= 1'b1;
            ACT_CLEAR: q <= 1'b0;
            default:   q <= q;
         endcase
      end
   end

endmodule

// File: rtl/ncl_thr_gate.sv
module ncl_thr_gate
   import ncl_thr_pkg::*;
#(
   parameter int unsigned M = 2,
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic         q
);

   localparam int unsigned CW = cnt_width(N);

   if (M < 1 || M > N) begin : g_bad_params
      $error("ncl_thr_gate: threshold M must satisfy 1 <= M <= N");
   end

   logic [CW-1:0] ones;
   thr_act_e      act;

   ncl_thr_count #(.N(N), .CW(CW)) u_count (
      .bits (din),
      .ones (ones)
   );

   ncl_thr_decide #(.M(M), .N(N), .CW(CW)) u_decide (
      .bits (din),
      .ones (ones),
      .act  (act)
   );

   ncl_thr_state u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .q     (q)
   );

   // R1 / R6 / R7: enough high inputs set the output at the next edge
   assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(din) >= M) |=> q);

   // R2: all inputs low clears the output at the next edge
   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (din == '0) |=> !q);

   // R3 / R8: partial input sets leave the output unchanged
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (($countones(din) < M) && (din != '0)) |=> (q == $past(q)));

   // R4 / R9: a reset seen at an edge keeps the output low at the next one
   assert_reset_low_R4: assert property (@(posedge clk)
      (!rst_n) |=> !q);

endmodule

// File: tb/sim_ncl_thr_gate.sv
module sim_ncl_thr_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] a = '0;
   logic [4:0] b = '0;
   logic [1:0] c = '0;
   logic       qa, qb, qc;
   int         errs = 0;
   int         checks = 0;
   logic       mb = 1'b0;
   logic       mc = 1'b0;
   bit         done = 0;

   always #2 clk = ~clk;

   ncl_thr_gate #(.M(2), .N(3)) u0 (.clk(clk), .rst_n(rst_n), .din(a), .q(qa));
   ncl_thr_gate #(.M(3), .N(5)) u1 (.clk(clk), .rst_n(rst_n), .din(b), .q(qb));
   ncl_thr_gate #(.M(2), .N(2)) u2 (.clk(clk), .rst_n(rst_n), .din(c), .q(qc));

   // {expected q, din} for the 2-of-3 gate, starting from q = 0
   localparam logic [3:0] TBL [15] = '{
      4'b0_000, 4'b0_001, 4'b1_011, 4'b1_010, 4'b0_000,
      4'b0_100, 4'b1_110, 4'b1_111, 4'b1_001, 4'b0_000,
      4'b1_101, 4'b1_100, 4'b0_000, 4'b1_111, 4'b0_000
   };

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step5(input logic [4:0] v, input string req);
      logic old;
      @(negedge clk);
      old = mb;
      b = v;
      #1 chk("R5", qb, old);
      if ($countones(v) >= 3) mb = 1'b1;
      else if (v == '0)       mb = 1'b0;
      @(negedge clk);
      chk(req, qb, mb);
   endtask

   task automatic step2(input logic [1:0] v, input string req);
      logic old;
      @(negedge clk);
      old = mc;
      c = v;
      #1 chk("R5", qc, old);
      if (v == 2'b11)      mc = 1'b1;
      else if (v == 2'b00) mc = 1'b0;
      @(negedge clk);
      chk(req, qc, mc);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: got hung expected finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      // R4: reset state
      repeat (2) @(negedge clk);
      chk("R4", qa, 1'b0);
      chk("R4", qb, 1'b0);
      chk("R4", qc, 1'b0);
      rst_n = 1'b1;

      // R6 / R1 / R2 / R3: table walk on the 2-of-3 gate
      for (int i = 0; i < 15; i++) begin
         logic old;
         @(negedge clk);
         old = qa;
         a = TBL[i][2:0];
         #1 chk("R5", qa, old);
         @(negedge clk);
         chk("R6", qa, TBL[i][3]);
      end

      // R7: 3-of-5 threshold and hysteresis
      step5(5'b00001, "R3");
      step5(5'b00011, "R7");
      step5(5'b00111, "R7");
      step5(5'b00110, "R3");
      step5(5'b10000, "R3");
      step5(5'b00000, "R2");
      step5(5'b11000, "R7");
      step5(5'b11100, "R1");
      step5(5'b11111, "R1");
      step5(5'b00000, "R2");

      // R8: C-element behaviour
      step2(2'b01, "R8");
      step2(2'b11, "R8");
      step2(2'b10, "R8");
      step2(2'b01, "R8");
      step2(2'b00, "R8");
      step2(2'b10, "R8");
      step2(2'b11, "R8");
      step2(2'b00, "R8");

      // R9: reset against a present set condition
      @(negedge clk);
      a = 3'b011;
      @(negedge clk);
      chk("R1", qa, 1'b1);
      rst_n = 1'b0;
      #1 chk("R4", qa, 1'b0);
      @(negedge clk);
      chk("R9", qa, 1'b0);
      @(negedge clk);
      chk("R9", qa, 1'b0);
      rst_n = 1'b1;
      #1 chk("R9", qa, 1'b0);
      @(negedge clk);
      chk("R9", qa, 1'b1);
      a = 3'b000;
      @(negedge clk);
      chk("R2", qa, 1'b0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule